// File: doc/BRIEF.md
# Retire-stage trap dispatcher

The block sits where instructions retire. On every clock edge it makes one of three choices: take a pending interrupt, take a pending exception, or let the retiring instruction commit. Only one of these happens in a cycle. The block holds four pieces of state. The first is a sticky vector of raised exception bits. The second is a mask of enabled exceptions. The third is the current interrupt priority. The fourth is an index into a stack of register contexts.

An interrupt may be taken only if its 64-bit pending vector meets a window set by the current priority. The window always includes bit 63. Each step of priority widens it by one bit toward bit 0. An interrupt that passes this test jumps to the context and priority it names, and its message goes into register 0 of that context. An exception moves the stack down by one context. It writes five registers of the handler context: register 0 gets the cause word, register 1 gets the faulting instruction word, and registers 2 to 4 get its three source operands. If no trap is taken, the retiring instruction's raised bits are merged into the sticky vector.

All outputs are registered. The register file is outside the block. Here it appears only as a write-enable vector, a target context and five data words. All of these are valid in the cycle after the decision.

Top module: `trap_dispatch`

## Requirements
- R1: After reset the state is as follows: the context index is all ones (7), the priority is 0, the raised vector is 0, the enabled mask is 0 and double_fault is 0. trap_taken is 0, trap_kind is 0 and wb_we is 0.
- R2: An interrupt is eligible only when irq_raised has a set bit at a position of 63−cur_prio or higher. Set bits below that position have no effect.
- R3: When an interrupt is eligible in the same cycle that an exception is pending, the interrupt is taken. The raised vector stays unchanged and the exception remains pending.
- R4: When an interrupt is taken, the following cycle shows these values: ctx_idx = irq_ctx, cur_prio = irq_prio, wb_ctx = irq_ctx, wb_data0 = irq_msg and wb_we = 5'b00001.
- R5: An exception is taken when raised_vec AND the enabled mask is nonzero and no interrupt is eligible. If ctx_idx was nonzero, it drops by one. wb_ctx is then the new index and wb_we = 5'b11111. wb_data1 is the zero-extended instruction word, and wb_data2 to wb_data4 are src_a, src_b and src_c.
- R6: The cause word in wb_data0 has bit 63 set and bits [7:0] holding the index of the lowest set bit of raised AND enabled. All other bits are 0.
- R7: When no trap is taken, raised_vec becomes raised_vec OR ret_raised. In a trap cycle, ret_raised is dropped.
- R8: Taking an exception clears from raised_vec the bits that were both raised and enabled. All other raised bits are kept.
- R9: An exception taken while ctx_idx is 0 sets double_fault and leaves ctx_idx at 0. double_fault then stays set until reset.
- R10: trap_kind is 0 for none, 1 for interrupt and 2 for exception, and 3 never occurs. trap_taken is high exactly when trap_kind is nonzero. In a cycle with no trap, wb_we is 0, and ctx_idx and cur_prio hold their values.
- R11: en_we loads en_wdata into the enabled mask. The new mask is first used for the decision made in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_raised | input | 16 | Raised bits of the retiring instruction |
| ret_inst | input | 32 | Instruction word of the retiring instruction |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| src_c | input | 64 | Third source operand |
| irq_raised | input | 64 | Pending interrupt vector |
| irq_msg | input | 64 | Interrupt message |
| irq_ctx | input | 3 | Target context of the interrupt |
| irq_prio | input | 6 | Priority of the interrupt |
| en_we | input | 1 | Write strobe for the enabled mask |
| en_wdata | input | 16 | New enabled mask |
| ctx_idx | output | 3 | Current context-stack index |
| cur_prio | output | 6 | Current priority |
| raised_vec | output | 16 | Sticky raised vector |
| double_fault | output | 1 | Sticky double-fault flag |
| trap_taken | output | 1 | One-cycle pulse for a taken trap |
| trap_kind | output | 2 | 0 none, 1 interrupt, 2 exception |
| wb_we | output | 5 | Write enables for registers 0 to 4 |
| wb_ctx | output | 3 | Context that receives the writes |
| wb_data0 | output | 64 | Register 0 data |
| wb_data1 | output | 64 | Register 1 data |
| wb_data2 | output | 64 | Register 2 data |
| wb_data3 | output | 64 | Register 3 data |
| wb_data4 | output | 64 | Register 4 data |

## Verification
Some rules hold in every cycle, and the assertions check these. They cover the legal encoding of the trap kind and its pulse. They cover the loading of context and priority on an interrupt, and the single-step descent on an exception together with its floor at context 0. They also cover the format of the cause flag, the OR-merge of raised bits when no trap is taken, and the stickiness of the double fault. Some behaviour only the bench scenarios can show. This covers the eligibility window at its exact edge bit and interrupts winning over exceptions. It also covers selection of the lowest cause index, clearing only the delivered raised bits, and the one-cycle delay of an enable-mask write.

// File: rtl/trap_dispatch.sv
module trap_dispatch #(
  parameter int XLEN    = 64,
  parameter int EXC_W   = 16,
  parameter int INST_W  = 32,
  parameter int CTX_W   = 3,
  parameter int PRIO_W  = 6,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EXC_W-1:0]   ret_raised,
  input  logic [INST_W-1:0]  ret_inst,
  input  logic [XLEN-1:0]    src_a,
  input  logic [XLEN-1:0]    src_b,
  input  logic [XLEN-1:0]    src_c,
  input  logic [XLEN-1:0]    irq_raised,
  input  logic [XLEN-1:0]    irq_msg,
  input  logic [CTX_W-1:0]   irq_ctx,
  input  logic [PRIO_W-1:0]  irq_prio,
  input  logic               en_we,
  input  logic [EXC_W-1:0]   en_wdata,
  output logic [CTX_W-1:0]   ctx_idx,
  output logic [PRIO_W-1:0]  cur_prio,
  output logic [EXC_W-1:0]   raised_vec,
  output logic               double_fault,
  output logic               trap_taken,
  output logic [1:0]         trap_kind,
  output logic [4:0]         wb_we,
  output logic [CTX_W-1:0]   wb_ctx,
  output logic [XLEN-1:0]    wb_data0,
  output logic [XLEN-1:0]    wb_data1,
  output logic [XLEN-1:0]    wb_data2,
  output logic [XLEN-1:0]    wb_data3,
  output logic [XLEN-1:0]    wb_data4
);

  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_IRQ  = 2'd1;
  localparam logic [1:0] KIND_EXC  = 2'd2;
  localparam logic [CTX_W-1:0] CTX_TOP = {CTX_W{1'b1}};
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic [EXC_W-1:0]   enabled_q;
  logic [XLEN-1:0]    win_seed;
  logic [XLEN-1:0]    irq_window;
  logic [EXC_W-1:0]   pend;
  logic               irq_hit;
  logic               exc_hit;
  logic               at_floor;
  logic [CAUSE_W-1:0] low_idx;
  logic [XLEN-1:0]    cause_word;

  assign win_seed   = {1'b1, {(XLEN-1){1'b0}}};
  assign irq_window = $signed(win_seed) >>> cur_prio;
  assign irq_hit    = |(irq_raised & irq_window);
  assign pend       = raised_vec & enabled_q;
  assign exc_hit    = |pend;
  assign at_floor   = (ctx_idx == '0);

  always_comb begin
    low_idx = '0;
    for (int i = EXC_W - 1; i >= 0; i--)
      if (pend[i]) low_idx = CAUSE_W'(i);
  end

  assign cause_word = {1'b1, {PAD_W{1'b0}}, low_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_idx      <= CTX_TOP;
      cur_prio     <= '0;
      raised_vec   <= '0;
      enabled_q    <= '0;
      double_fault <= 1'b0;
      trap_taken   <= 1'b0;
      trap_kind    <= KIND_NONE;
      wb_we        <= '0;
      wb_ctx       <= '0;
      wb_data0     <= '0;
      wb_data1     <= '0;
      wb_data2     <= '0;
      wb_data3     <= '0;
      wb_data4     <= '0;
    end else begin
      trap_taken <= irq_hit | exc_hit;
      if (irq_hit) begin
        trap_kind <= KIND_IRQ;
        ctx_idx   <= irq_ctx;
        cur_prio  <= irq_prio;
        wb_we     <= 5'b00001;
        wb_ctx    <= irq_ctx;
        wb_data0  <= irq_msg;
      end else if (exc_hit) begin
        trap_kind    <= KIND_EXC;
        ctx_idx      <= at_floor ? ctx_idx : ctx_idx - 1'b1;
        double_fault <= double_fault | at_floor;
        raised_vec   <= raised_vec & ~pend;
        wb_we        <= 5'b11111;
        wb_ctx       <= at_floor ? ctx_idx : ctx_idx - 1'b1;
        wb_data0     <= cause_word;
        wb_data1     <= XLEN'(ret_inst);
        wb_data2     <= src_a;
        wb_data3     <= src_b;
        wb_data4     <= src_c;
      end else begin
        trap_kind  <= KIND_NONE;
        wb_we      <= '0;
        raised_vec <= raised_vec | ret_raised;
      end
      if (en_we) enabled_q <= en_wdata;
    end
  end

endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
  parameter int XLEN    = 64,
  parameter int EXC_W   = 16,
  parameter int CTX_W   = 3,
  parameter int PRIO_W  = 6,
  parameter int CAUSE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EXC_W-1:0]  ret_raised,
  input logic [XLEN-1:0]   irq_msg,
  input logic [CTX_W-1:0]  irq_ctx,
  input logic [PRIO_W-1:0] irq_prio,
  input logic [CTX_W-1:0]  ctx_idx,
  input logic [PRIO_W-1:0] cur_prio,
  input logic [EXC_W-1:0]  raised_vec,
  input logic              double_fault,
  input logic              trap_taken,
  input logic [1:0]        trap_kind,
  input logic [4:0]        wb_we,
  input logic [XLEN-1:0]   wb_data0
);

  logic seen;
  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  assert_kind_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_kind != 2'd3);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken == (trap_kind != 2'd0));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen && trap_kind == 2'd0 |->
      wb_we == 5'd0 && ctx_idx == $past(ctx_idx) && cur_prio == $past(cur_prio));

  assert_irq_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && trap_kind == 2'd1 |->
      ctx_idx == $past(irq_ctx) && cur_prio == $past(irq_prio) &&
      wb_data0 == $past(irq_msg) && wb_we == 5'b00001);

  assert_exc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && trap_kind == 2'd2 && $past(ctx_idx) != '0 |->
      ctx_idx == CTX_W'($past(ctx_idx) - 1'b1) && wb_we == 5'b11111);

  assert_cause_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_kind == 2'd2 |-> wb_data0[XLEN-1] && wb_data0[XLEN-2:CAUSE_W] == '0);

  assert_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && trap_kind == 2'd0 |->
      raised_vec == ($past(raised_vec) | $past(ret_raised)));

  assert_df_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(double_fault) |-> double_fault);

  assert_df_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && trap_kind == 2'd2 && $past(ctx_idx) == '0 |->
      ctx_idx == '0 && double_fault);

endmodule

bind trap_dispatch trap_dispatch_chk #(
  .XLEN(XLEN), .EXC_W(EXC_W), .CTX_W(CTX_W), .PRIO_W(PRIO_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_raised(ret_raised), .irq_msg(irq_msg),
  .irq_ctx(irq_ctx), .irq_prio(irq_prio), .ctx_idx(ctx_idx), .cur_prio(cur_prio),
  .raised_vec(raised_vec), .double_fault(double_fault), .trap_taken(trap_taken),
  .trap_kind(trap_kind), .wb_we(wb_we), .wb_data0(wb_data0)
);

// File: tb/trap_dispatch_tb.sv
module trap_dispatch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] ret_raised = '0;
  logic [31:0] ret_inst = '0;
  logic [63:0] src_a = '0, src_b = '0, src_c = '0;
  logic [63:0] irq_raised = '0, irq_msg = '0;
  logic [2:0]  irq_ctx = '0;
  logic [5:0]  irq_prio = '0;
  logic        en_we = 1'b0;
  logic [15:0] en_wdata = '0;

  logic [2:0]  ctx_idx, wb_ctx;
  logic [5:0]  cur_prio;
  logic [15:0] raised_vec;
  logic        double_fault, trap_taken;
  logic [1:0]  trap_kind;
  logic [4:0]  wb_we;
  logic [63:0] wb_data0, wb_data1, wb_data2, wb_data3, wb_data4;

  trap_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .ret_raised(ret_raised), .ret_inst(ret_inst),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .irq_raised(irq_raised),
    .irq_msg(irq_msg), .irq_ctx(irq_ctx), .irq_prio(irq_prio), .en_we(en_we),
    .en_wdata(en_wdata), .ctx_idx(ctx_idx), .cur_prio(cur_prio),
    .raised_vec(raised_vec), .double_fault(double_fault), .trap_taken(trap_taken),
    .trap_kind(trap_kind), .wb_we(wb_we), .wb_ctx(wb_ctx), .wb_data0(wb_data0),
    .wb_data1(wb_data1), .wb_data2(wb_data2), .wb_data3(wb_data3), .wb_data4(wb_data4)
  );

  int total = 0, fails = 0;
  logic [2:0]  m_ctx = 3'd7;
  logic [5:0]  m_prio = '0;
  logic [15:0] m_raised = '0, m_en = '0;
  logic        m_df = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] window(logic [5:0] p);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) if (i >= 63 - int'(p)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] cause_of(logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return {1'b1, 55'd0, 8'(i)};
    return '0;
  endfunction

  task automatic idle();
    ret_raised = '0; irq_raised = '0; en_we = 1'b0;
  endtask

  task automatic step();
    logic [1:0]  k;
    logic [2:0]  nctx, wctx;
    logic [5:0]  nprio;
    logic [15:0] nraised, pend;
    logic        ndf;
    logic [4:0]  we;
    logic [63:0] d0;
    nctx = m_ctx; nprio = m_prio; nraised = m_raised; ndf = m_df;
    pend = m_raised & m_en; wctx = '0; d0 = '0;
    if (|(irq_raised & window(m_prio))) begin
      k = 2'd1; nctx = irq_ctx; nprio = irq_prio; wctx = irq_ctx; we = 5'b00001; d0 = irq_msg;
    end else if (|pend) begin
      k = 2'd2; we = 5'b11111; d0 = cause_of(pend); nraised = m_raised & ~pend;
      if (m_ctx == 0) ndf = 1'b1; else nctx = m_ctx - 3'd1;
      wctx = nctx;
    end else begin
      k = 2'd0; we = 5'd0; nraised = m_raised | ret_raised;
    end
    @(posedge clk); @(negedge clk);
    chk("R10 trap_kind", 64'(trap_kind), 64'(k));
    chk("R10 trap_taken", 64'(trap_taken), 64'(k != 0));
    chk("R10 wb_we", 64'(wb_we), 64'(we));
    chk("R4 R5 R9 ctx_idx", 64'(ctx_idx), 64'(nctx));
    chk("R4 cur_prio", 64'(cur_prio), 64'(nprio));
    chk("R7 R8 raised_vec", 64'(raised_vec), 64'(nraised));
    chk("R9 double_fault", 64'(double_fault), 64'(ndf));
    if (k != 0) begin
      chk("R4 R5 wb_ctx", 64'(wb_ctx), 64'(wctx));
      chk("R4 R6 wb_data0", wb_data0, d0);
    end
    if (k == 2'd2) begin
      chk("R5 wb_data1", wb_data1, 64'(ret_inst));
      chk("R5 wb_data2", wb_data2, src_a);
      chk("R5 wb_data3", wb_data3, src_b);
      chk("R5 wb_data4", wb_data4, src_c);
    end
    m_ctx = nctx; m_prio = nprio; m_raised = nraised; m_df = ndf;
    if (en_we) m_en = en_wdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ctx_idx", 64'(ctx_idx), 64'd7);
    chk("R1 cur_prio", 64'(cur_prio), 64'd0);
    chk("R1 raised_vec", 64'(raised_vec), 64'd0);
    chk("R1 double_fault", 64'(double_fault), 64'd0);
    chk("R1 trap_taken", 64'(trap_taken), 64'd0);
    chk("R1 trap_kind", 64'(trap_kind), 64'd0);
    chk("R1 wb_we", 64'(wb_we), 64'd0);
    rst_n = 1'b1;

    // R11: enable write plus raised bits in the same cycle, no trap yet
    en_we = 1'b1; en_wdata = 16'h0014; ret_raised = 16'h0034;
    ret_inst = 32'hCAFE_0001; src_a = 64'h11; src_b = 64'h22; src_c = 64'h33;
    step();
    chk("R11 no exception before mask in effect", 64'(trap_kind), 64'd0);
    idle();
    step();
    // R6: lowest of 0x14 is bit 2; R8: bit 5 survives
    chk("R6 cause index", wb_data0, {1'b1, 55'd0, 8'd2});
    chk("R8 undelivered bit kept", 64'(raised_vec), 64'h0020);

    // R2: priority 0 window is bit 63 only
    irq_raised = 64'h4000_0000_0000_0000; irq_msg = 64'hAA; irq_ctx = 3'd5; irq_prio = 6'd3;
    step();
    chk("R2 bit 62 ignored at prio 0", 64'(trap_kind), 64'd0);

    // R3: interrupt wins while exception pending
    idle(); ret_raised = 16'h0004; step();
    irq_raised = 64'h8000_0000_0000_0000; irq_msg = 64'h1234_5678;
    step();
    chk("R3 interrupt over exception", 64'(trap_kind), 64'd1);
    chk("R3 exception stays pending", 64'(raised_vec), 64'h0024);
    idle(); step();
    chk("R5 exception after interrupt", 64'(trap_kind), 64'd2);

    // R2: priority 3 window edge at bit 60
    irq_raised = 64'h0800_0000_0000_0000; step();
    chk("R2 bit 59 outside prio 3 window", 64'(trap_kind), 64'd0);
    irq_raised = 64'h1000_0000_0000_0000; irq_ctx = 3'd0; irq_prio = 6'd0; step();
    chk("R2 bit 60 inside prio 3 window", 64'(trap_kind), 64'd1);

    // R9: exception at context 0
    idle(); ret_raised = 16'h0010; step();
    idle(); step();
    chk("R9 double fault set", 64'(double_fault), 64'd1);
    chk("R9 ctx stays 0", 64'(ctx_idx), 64'd0);

    for (int n = 0; n < 400; n++) begin
      ret_raised = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'd0;
      ret_inst = $urandom;
      src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; src_c = {$urandom, $urandom};
      irq_raised = ($urandom % 8 == 0) ? (64'd1 << ($urandom % 64)) : 64'd0;
      irq_msg = {$urandom, $urandom};
      irq_ctx = 3'($urandom); irq_prio = 6'($urandom);
      en_we = ($urandom % 10 == 0); en_wdata = 16'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule